// File: doc/BRIEF.md
# Receiver Error Interrupt and Output Mute Controller

This block sits behind a digital audio receiver and turns its per-frame error and status lines into two interrupt outputs, a protected serial sample output and a validity output. One interrupt line groups the link-integrity errors (loss of lock, parity failure, validity) and is stretched for a selectable number of frame periods after those errors go away, so a host polling slowly still sees a glitch. The other interrupt line groups the content-type changes (non-PCM stream, audio/non-audio flag, and the three sticky event flags) and follows its sources with no stretch.

A mode input picks between a fixed wiring, where masks are ignored and the stretch is always twice the base length, and a programmable wiring, where a mask vector removes individual events from the interrupts and a two-bit field picks the stretch length. While lock is lost the programmable wiring falls back to the fixed grouping. The audio path forces zero while unlocked, repeats the last clean sample while only a parity error is present, and otherwise passes the incoming sample straight through. Real-time status bits mirror the level events, and three sticky bits catch pulse events until the host reads them.

Top module: `rx_err_irq_mute`

## Requirements
- R1: With `serial_mode`=0, `int0` is high whenever `ev_unlock` or `ev_parity` is high and `int1` equals `ev_nonpcm` OR `ev_audio` in the same cycle; `irq_mask` and `hold_sel` have no effect.
- R2: Once `int0`'s sources clear, `int0` stays high until N `fs_tick` cycles have been seen after the clear, and is low in the cycle after the Nth tick; any active source restarts the count, and with no tick `int0` never falls. With `serial_mode`=0, N = 2*HOLD_BASE.
- R3: With `serial_mode`=1, N = HOLD_BASE << `hold_sel` (00, 01, 10, 11 give 1, 2, 4, 8 times HOLD_BASE; with HOLD_BASE=512 these are 512, 1024, 2048, 4096 frames).
- R4: With `serial_mode`=1 and no unlock, `int0` sources are the unmasked events among unlock (mask bit 0), parity (bit 1) and validity (bit 4); `int1` sources are the unmasked ones among non-PCM (bit 2), audio (bit 3) and the sticky Q-subcode (bit 5), channel-change (bit 6) and DAT (bit 7) flags; a mask bit of 1 removes the event, and `int1` has no stretch.
- R5: Mask bits never change `rt_status` or `sticky_status`.
- R6: `rt_status` bits 0..4 equal unlock, parity, non-PCM, audio and validity in the same cycle.
- R7: `sticky_status` bits 0..2 (Q-subcode, channel-change, DAT) go to 1 the cycle after their event pulse and hold; the cycle after `rd_stb` they go to 0 unless their event was high in the `rd_stb` cycle, in which case they stay 1.
- R8: While `ev_unlock` is high, `sdata_out` is 0 and `vout` is 0; otherwise `vout` equals `ev_valid`.
- R9: With `ev_parity` high and `ev_unlock` low, `sdata_out` equals the `sdata_in` of the last cycle in which both were low (0 if none since reset); with both low, `sdata_out` equals `sdata_in` in the same cycle.
- R10: With `serial_mode`=1 and `ev_unlock` high, the interrupts use the R1 grouping and ignore `irq_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fs_tick | input | 1 | One-cycle pulse per audio frame |
| serial_mode | input | 1 | 0 fixed wiring, 1 programmable wiring |
| hold_sel | input | 2 | Stretch length select (serial mode) |
| irq_mask | input | 8 | Per-event interrupt mask, 1 = masked |
| ev_unlock | input | 1 | Receiver lock lost |
| ev_parity | input | 1 | Parity error |
| ev_nonpcm | input | 1 | Non-PCM stream detected |
| ev_audio | input | 1 | Non-audio flag |
| ev_valid | input | 1 | Validity flag of the current frame |
| ev_qsub | input | 1 | Q-subcode update pulse |
| ev_cschg | input | 1 | Channel status change pulse |
| ev_dat | input | 1 | DAT start pulse |
| rd_stb | input | 1 | Host read of the status register |
| sdata_in | input | DW | Incoming audio sample |
| int0 | output | 1 | Stretched error interrupt |
| int1 | output | 1 | Unstretched status interrupt |
| sdata_out | output | DW | Muted, held or passed sample |
| vout | output | 1 | Validity output |
| rt_status | output | 5 | Real-time event mirror |
| sticky_status | output | 3 | Clear-on-read event flags |

## Verification
The rising edge of each interrupt, the real-time status, the data output and `vout` are combinational, so the bench drives inputs just after a clock edge and samples them at the falling edge of the same cycle. Sticky bits are due one edge after the event or read, and the bench samples them at the falling edge of the following cycle. The `int0` stretch is measured by counting falling edges with `int0` high after the sources drop, which must equal N exactly when a tick arrives every cycle. The data path is checked every cycle against a bench model that records the last clean sample at each rising edge.

// File: rtl/rx_err_irq_mute.sv
module rx_err_irq_mute #(
  parameter int DW = 24,
  parameter int HOLD_BASE = 512,
  localparam int LIM_MAX = HOLD_BASE * 8,
  localparam int CW = $clog2(LIM_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fs_tick,
  input  logic          serial_mode,
  input  logic [1:0]    hold_sel,
  input  logic [7:0]    irq_mask,
  input  logic          ev_unlock,
  input  logic          ev_parity,
  input  logic          ev_nonpcm,
  input  logic          ev_audio,
  input  logic          ev_valid,
  input  logic          ev_qsub,
  input  logic          ev_cschg,
  input  logic          ev_dat,
  input  logic          rd_stb,
  input  logic [DW-1:0] sdata_in,
  output logic          int0,
  output logic          int1,
  output logic [DW-1:0] sdata_out,
  output logic          vout,
  output logic [4:0]    rt_status,
  output logic [2:0]    sticky_status
);
  localparam logic [7:0] GRP0 = 8'b0001_0011;
  localparam logic [7:0] GRP1 = 8'b1110_1100;

  logic [2:0]    sticky_q;
  logic          stretch;
  logic [CW-1:0] cnt;
  logic [DW-1:0] last_good;
  logic [7:0]    evs;
  logic          fixed_grp, src0, src1, clean;
  logic [CW-1:0] lim;

  assign evs = {sticky_q, ev_valid, ev_audio, ev_nonpcm, ev_parity, ev_unlock};
  assign fixed_grp = !serial_mode || ev_unlock;
  assign src0 = fixed_grp ? (ev_unlock | ev_parity) : |(evs & ~irq_mask & GRP0);
  assign src1 = fixed_grp ? (ev_nonpcm | ev_audio) : |(evs & ~irq_mask & GRP1);
  assign lim = serial_mode ? (CW'(HOLD_BASE) << hold_sel) : CW'(HOLD_BASE * 2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stretch <= 1'b0;
      cnt     <= '0;
    end else if (src0) begin
      stretch <= 1'b1;
      cnt     <= '0;
    end else if (stretch && fs_tick) begin
      if (cnt >= lim - CW'(1)) begin
        stretch <= 1'b0;
        cnt     <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assign int0 = src0 | stretch;
  assign int1 = src1;

  always_ff @(posedge clk) begin
    if (!rst_n) sticky_q <= '0;
    else        sticky_q <= (rd_stb ? 3'b000 : sticky_q) | {ev_dat, ev_cschg, ev_qsub};
  end

  assign sticky_status = sticky_q;
  assign rt_status = {ev_valid, ev_audio, ev_nonpcm, ev_parity, ev_unlock};

  assign clean = !ev_unlock && !ev_parity;

  always_ff @(posedge clk) begin
    if (!rst_n)     last_good <= '0;
    else if (clean) last_good <= sdata_in;
  end

  assign sdata_out = ev_unlock ? '0 : (ev_parity ? last_good : sdata_in);
  assign vout = ev_valid & ~ev_unlock;

  // R8
  unlock_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unlock |-> (sdata_out == '0 && !vout));

  // R9
  parity_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_parity && !ev_unlock && $past(ev_parity && !ev_unlock)) |-> $stable(sdata_out));

  // R2
  int0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int0 && !fs_tick) |=> int0);

  // R2
  int0_fall_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int0) |-> $past(fs_tick));

  // R7
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dat |=> sticky_status[2]);

  // R7
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !ev_qsub) |=> !sticky_status[0]);
endmodule

// File: tb/rx_err_irq_mute_test.sv
module rx_err_irq_mute_test;
  localparam int DW = 16;
  localparam int HB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fs_tick = 1'b1;
  logic serial_mode = 1'b0;
  logic [1:0] hold_sel = 2'b01;
  logic [7:0] irq_mask = 8'h00;
  logic [7:0] ev = 8'h00;
  logic rd_stb = 1'b0;
  logic [DW-1:0] sdata_in = '0;
  logic int0, int1, vout;
  logic [DW-1:0] sdata_out;
  logic [4:0] rt_status;
  logic [2:0] sticky_status;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rx_err_irq_mute #(.DW(DW), .HOLD_BASE(HB)) uut (
    .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick), .serial_mode(serial_mode),
    .hold_sel(hold_sel), .irq_mask(irq_mask),
    .ev_unlock(ev[0]), .ev_parity(ev[1]), .ev_nonpcm(ev[2]), .ev_audio(ev[3]),
    .ev_valid(ev[4]), .ev_qsub(ev[5]), .ev_cschg(ev[6]), .ev_dat(ev[7]),
    .rd_stb(rd_stb), .sdata_in(sdata_in), .int0(int0), .int1(int1),
    .sdata_out(sdata_out), .vout(vout), .rt_status(rt_status),
    .sticky_status(sticky_status));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic measure_hold(input int n, input string req);
    int c = 0;
    ev = 8'h00;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!int0) break;
      c++;
      step();
    end
    check(c == n, req, c, n);
  endtask

  task automatic clear_all();
    ev = 8'h00; rd_stb = 1'b1; step(); rd_stb = 1'b0;
    repeat (80) step();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] model_last;
    logic [DW-1:0] exp_d;
    repeat (3) step();
    @(negedge clk);
    check(int0 == 0 && int1 == 0 && sticky_status == 0, "reset", {int0, int1, sticky_status}, 0);
    rst_n = 1'b1; step();

    // R1: fixed grouping, masks ignored
    irq_mask = 8'hFF; hold_sel = 2'b11;
    for (int v = 0; v < 16; v++) begin
      ev = 8'(v); @(negedge clk);
      check(int0 == ((v & 3) != 0), "R1 int0", int0, (v & 3) != 0);
      check(int1 == ((v & 12) != 0), "R1 int1", int1, (v & 12) != 0);
      step();
      clear_all();
    end

    // R2: parallel stretch 2*HB, restart, no-tick hold
    irq_mask = 8'h00;
    ev = 8'h01; repeat (3) step();
    measure_hold(2 * HB, "R2 parallel stretch");
    ev = 8'h02; step(); ev = 8'h00; step(); step();
    ev = 8'h02; step();
    measure_hold(2 * HB, "R2 restart");
    ev = 8'h02; step(); ev = 8'h00; fs_tick = 1'b0;
    repeat (50) step();
    @(negedge clk);
    check(int0 == 1, "R2 no tick no fall", int0, 1);
    step(); fs_tick = 1'b1;
    measure_hold(2 * HB, "R2 after ticks resume");

    // R3: serial hold lengths
    serial_mode = 1'b1;
    for (int s = 0; s < 4; s++) begin
      hold_sel = 2'(s);
      ev = 8'h02; repeat (2) step();
      measure_hold(HB << s, "R3 hold_sel");
    end
    hold_sel = 2'b00;

    // R4 R5 R6 R7 R10: per-event mask sweep in serial mode
    for (int e = 0; e < 8; e++) begin
      for (int m = 0; m < 2; m++) begin
        bit x0, x1;
        irq_mask = m ? 8'(1 << e) : 8'h00;
        x0 = (e == 0) ? 1'b1 : (!m && (e == 1 || e == 4));
        x1 = (e == 0) ? 1'b0 : (!m && (e == 2 || e == 3 || e >= 5));
        ev = 8'(1 << e);
        @(negedge clk);
        check(rt_status == ((e < 5) ? 5'(1 << e) : 5'd0), "R6 R5 rt_status", rt_status,
              (e < 5) ? (1 << e) : 0);
        check(int0 == x0, (e == 0) ? "R10 int0 unlock" : "R4 int0", int0, x0);
        if (e < 5) check(int1 == x1, (e == 0) ? "R10 int1 unlock" : "R4 int1", int1, x1);
        step();
        if (e >= 5) ev = 8'h00;
        @(negedge clk);
        check(sticky_status == ((e >= 5) ? 3'(1 << (e - 5)) : 3'd0), "R7 R5 sticky set",
              sticky_status, (e >= 5) ? (1 << (e - 5)) : 0);
        if (e >= 5) check(int1 == x1, "R4 int1 sticky", int1, x1);
        ev = 8'h00; rd_stb = 1'b1; step(); rd_stb = 1'b0;
        @(negedge clk);
        check(sticky_status == 0 && int1 == 0, "R7 R4 cleared, int1 no stretch",
              {sticky_status, int1}, 0);
        repeat (20) step();
      end
    end

    // R10: unlock overrides masks for int1
    irq_mask = 8'hFF; ev = 8'h05; @(negedge clk);
    check(int1 == 1, "R10 int1 unlock ignores mask", int1, 1);
    step(); clear_all();
    irq_mask = 8'h00;

    // R7: event in the read cycle keeps the bit
    ev = 8'h80; step(); ev = 8'h80; rd_stb = 1'b1; step(); ev = 8'h00; rd_stb = 1'b0;
    @(negedge clk);
    check(sticky_status[2] == 1, "R7 read with event", sticky_status[2], 1);
    rd_stb = 1'b1; step(); rd_stb = 1'b0;
    @(negedge clk);
    check(sticky_status[2] == 0, "R7 read clears", sticky_status[2], 0);
    clear_all();

    // R8 R9: data path sweep
    model_last = '0;
    rst_n = 1'b0; step(); rst_n = 1'b1;
    for (int i = 0; i < 300; i++) begin
      bit u, p, v;
      u = (i % 11) == 5;
      p = ((i % 7) == 3) || ((i % 7) == 4) || (i == 0);
      v = (i % 3) == 0;
      ev = {3'b000, v, 2'b00, p, u};
      sdata_in = DW'(i * 12345 + 7);
      @(negedge clk);
      exp_d = u ? '0 : (p ? model_last : sdata_in);
      check(sdata_out == exp_d, u ? "R8 mute" : "R9 data", sdata_out, exp_d);
      check(vout == (v && !u), "R8 vout", vout, v && !u);
      @(posedge clk);
      if (!u && !p) model_last = sdata_in;
      #1;
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule